// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from a fixed set of on-chip peripherals, a bank of maskable auxiliary sources and a 4-bit encoded external request level. It picks one winner among them every cycle and drives the winner's priority to the CPU as a request level. When the CPU acknowledges, the block captures the winner's event code, so the exception handler can read it and dispatch.

Priorities are held in two 16-bit priority registers. Each register holds four 4-bit fields. Several peripherals form groups that share a single field. The auxiliary sources are gated by a mask register, which is written through separate set and clear addresses. All requests are level sensitive and are evaluated again on every clock.

Top module: `pvic_top`

## Requirements
- R1: After reset, `level_o` is 0, `evt_code_o` is 0, both priority registers are 0 and every auxiliary source is masked. A request from an auxiliary source then produces no level.
- R2: Writes use `wr_addr_i` 0 for priority register A and 1 for priority register B, with the data in bits [15:0]. In register A, bits [15:12] hold the priority of timer0 (code 0x400) and bits [11:8] the priority of timer1 (code 0x420). A field of 0 disables its source.
- R3: Grouped sources share one field. Timer2 underflow (0x440) and timer2 capture (0x460) use A[7:4]. The three RTC requests (0x480, 0x4A0, 0x4C0) use A[3:0]. In register B, B[15:12] is the watchdog (0x560), B[11:8] is GPIO (0x620), B[7:4] is debug (0x600), and B[3:0] is shared by all auxiliary sources (auxiliary k has code 0xB00 + 0x20·k).
- R4: A write to address 2 masks each auxiliary source whose data bit is 1. A write to address 3 unmasks each auxiliary source whose data bit is 1. Bits written as 0 leave the mask unchanged.
- R5: One cycle after the inputs are sampled, `level_o` equals the highest priority among the enabled, unmasked, pending candidates, or 0 when there is none.
- R6: When candidates tie on priority, the one with the lower index wins. Requests on `req_i` bits 0..9 are timer0, timer1, timer2 underflow, timer2 capture, RTC 0..2, watchdog, GPIO and debug. Bits 10 and above are the auxiliary sources. The external request ranks after all internal requests.
- R7: An external level n (0..14) on `ext_lvl_i` requests priority 15−n with event code 0x200 + 0x20·n. The value 0xF means no external request.
- R8: On a cycle with `ack_i` high and a candidate pending, `evt_code_o` takes the winner's code on the next cycle. Without an acknowledge, `evt_code_o` holds its value.
- R9: A request that is withdrawn before it is acknowledged drops out: one cycle later the level reflects only the requests that remain.
- R10: An acknowledge while nothing is pending leaves `evt_code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 prio A, 1 prio B, 2 mask set, 3 mask clear |
| wr_data_i | input | DW (32) | Write data |
| req_i | input | N_INT (42) | Level-sensitive internal requests |
| ext_lvl_i | input | 4 | Encoded external request level, 0xF = none |
| ack_i | input | 1 | CPU acknowledge |
| level_o | output | 4 | Priority of the current winner, 0 = none |
| evt_code_o | output | 12 | Event code captured at the last acknowledge |

## Verification
The properties assume that `req_i`, `ext_lvl_i` and `ack_i` are synchronous to the clock and stay steady through each edge. They make no assumption about the contents of the priority or mask registers, so the level checks are tied only to cycles in which no internal line is asserted. The stimulus changes every input half a period away from the rising edge and keeps register writes in cycles of their own. As a result, each expected level depends on register values that are already settled.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned PRIO_W    = 4;
  localparam int unsigned CODE_W    = 12;
  localparam int unsigned N_FIX     = 10;
  localparam int unsigned N_FLD     = 8;
  localparam logic [CODE_W-1:0] AUX_BASE  = 12'hB00;
  localparam logic [CODE_W-1:0] EXT_BASE  = 12'h200;
  localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;

  // nibble index into {prio_b, prio_a}
  function automatic int unsigned fld_of(int unsigned src);
    case (src)
      0:       return 3;
      1:       return 2;
      2, 3:    return 1;
      4, 5, 6: return 0;
      7:       return 7;
      8:       return 6;
      9:       return 5;
      default: return 4;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] code_of(int unsigned src);
    case (src)
      0:       return 12'h400;
      1:       return 12'h420;
      2:       return 12'h440;
      3:       return 12'h460;
      4:       return 12'h480;
      5:       return 12'h4A0;
      6:       return 12'h4C0;
      7:       return 12'h560;
      8:       return 12'h620;
      9:       return 12'h600;
      default: return AUX_BASE + CODE_W'(src - N_FIX) * CODE_STEP;
    endcase
  endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs #(
  parameter int unsigned N_AUX = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    wr_en_i,
  input  logic [1:0]                              wr_addr_i,
  input  logic [DW-1:0]                           wr_data_i,
  output logic [pvic_pkg::N_FLD*pvic_pkg::PRIO_W-1:0] prio_o,
  output logic [N_AUX-1:0]                        mask_o
);
  localparam int unsigned HW = 16;

  logic [HW-1:0]    prio_a_q, prio_b_q;
  logic [N_AUX-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_a_q <= '0;
      prio_b_q <= '0;
      mask_q   <= '1;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        2'd0: prio_a_q <= wr_data_i[HW-1:0];
        2'd1: prio_b_q <= wr_data_i[HW-1:0];
        2'd2: mask_q   <= mask_q | wr_data_i[N_AUX-1:0];
        default: mask_q <= mask_q & ~wr_data_i[N_AUX-1:0];
      endcase
    end
  end

  assign prio_o = {prio_b_q, prio_a_q};
  assign mask_o = mask_q;
endmodule

// File: rtl/pvic_cand.sv
module pvic_cand #(
  parameter int unsigned N_AUX = 32,
  localparam int unsigned N_INT  = pvic_pkg::N_FIX + N_AUX,
  localparam int unsigned N_CAND = N_INT + 1,
  localparam int unsigned PW     = pvic_pkg::PRIO_W,
  localparam int unsigned CW     = pvic_pkg::CODE_W
) (
  input  logic [N_INT-1:0]                 req_i,
  input  logic [pvic_pkg::N_FLD*PW-1:0]    prio_i,
  input  logic [N_AUX-1:0]                 mask_i,
  input  logic [3:0]                       ext_lvl_i,
  output logic [N_CAND-1:0][PW-1:0]        cprio_o,
  output logic [N_CAND-1:0][CW-1:0]        ccode_o
);
  localparam logic [3:0] EXT_NONE = 4'hF;

  for (genvar i = 0; i < N_INT; i++) begin : g_src
    localparam int unsigned F = pvic_pkg::fld_of(i);
    logic live;
    if (i < pvic_pkg::N_FIX) begin : g_fix
      assign live = req_i[i];
    end else begin : g_aux
      assign live = req_i[i] & ~mask_i[i-pvic_pkg::N_FIX];
    end
    assign cprio_o[i] = live ? prio_i[F*PW +: PW] : '0;
    assign ccode_o[i] = pvic_pkg::code_of(i);
  end

  assign cprio_o[N_INT] = (ext_lvl_i == EXT_NONE) ? '0 : PW'(4'd15 - ext_lvl_i);
  assign ccode_o[N_INT] = pvic_pkg::EXT_BASE + CW'(ext_lvl_i) * pvic_pkg::CODE_STEP;
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int unsigned N  = 43,
  parameter int unsigned PW = 4,
  parameter int unsigned CW = 12
) (
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic [N-1:0][CW-1:0] code_i,
  output logic                 valid_o,
  output logic [PW-1:0]        prio_o,
  output logic [CW-1:0]        code_o
);
  // strict compare: earlier index keeps a tie
  always_comb begin
    prio_o = '0;
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (prio_i[i] > prio_o) begin
        prio_o = prio_i[i];
        code_o = code_i[i];
      end
    end
    valid_o = (prio_o != '0);
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int unsigned N_AUX = 32,
  localparam int unsigned N_INT = pvic_pkg::N_FIX + N_AUX,
  localparam int unsigned DW    = (N_AUX > 16) ? N_AUX : 16,
  localparam int unsigned PW    = pvic_pkg::PRIO_W,
  localparam int unsigned CW    = pvic_pkg::CODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [N_INT-1:0] req_i,
  input  logic [3:0]       ext_lvl_i,
  input  logic             ack_i,
  output logic [PW-1:0]    level_o,
  output logic [CW-1:0]    evt_code_o
);
  localparam int unsigned N_CAND = N_INT + 1;

  logic [pvic_pkg::N_FLD*PW-1:0] prio;
  logic [N_AUX-1:0]              mask;
  logic [N_CAND-1:0][PW-1:0]     cprio;
  logic [N_CAND-1:0][CW-1:0]     ccode;
  logic                          win_valid;
  logic [PW-1:0]                 win_prio;
  logic [CW-1:0]                 win_code;
  logic [PW-1:0]                 level_q;
  logic [CW-1:0]                 code_q;

  pvic_regs #(.N_AUX(N_AUX), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .prio_o(prio), .mask_o(mask)
  );

  pvic_cand #(.N_AUX(N_AUX)) u_cand (
    .req_i, .prio_i(prio), .mask_i(mask), .ext_lvl_i,
    .cprio_o(cprio), .ccode_o(ccode)
  );

  pvic_arb #(.N(N_CAND), .PW(PW), .CW(CW)) u_arb (
    .prio_i(cprio), .code_i(ccode),
    .valid_o(win_valid), .prio_o(win_prio), .code_o(win_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      code_q  <= '0;
    end else begin
      level_q <= win_prio;
      if (ack_i && win_valid) code_q <= win_code;
    end
  end

  assign level_o    = level_q;
  assign evt_code_o = code_q;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int unsigned N_AUX = 32,
  localparam int unsigned N_INT = pvic_pkg::N_FIX + N_AUX,
  localparam int unsigned DW    = (N_AUX > 16) ? N_AUX : 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [N_INT-1:0] req_i,
  input logic [3:0]       ext_lvl_i,
  input logic             ack_i,
  input logic [3:0]       level_o,
  input logic [11:0]      evt_code_o
);
  // R7
  ext_only_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && ext_lvl_i != 4'hF) |=> level_o == 4'(4'd15 - $past(ext_lvl_i)));

  // R9
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && ext_lvl_i == 4'hF) |=> level_o == 4'd0);

  // R8
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(evt_code_o));

  // R10
  empty_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_i == '0 && ext_lvl_i == 4'hF) |=> $stable(evt_code_o));
endmodule

bind pvic_top pvic_chk #(.N_AUX(N_AUX)) u_chk (.*);

// File: tb/pvic_top_test.sv
`timescale 1ns/1ps
module pvic_top_test;
  localparam int NA = 32;
  localparam int NI = 10 + NA;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [1:0]    wr_addr = 0;
  logic [31:0]   wr_data = 0;
  logic [NI-1:0] req = '0;
  logic [3:0]    ext = 4'hF;
  logic          ack = 0;
  logic [3:0]    level;
  logic [11:0]   code;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [15:0] m_pa = 0, m_pb = 0;
  logic [NA-1:0] m_mask = '1;
  logic [11:0] exp_code = 0;

  string       tq[$];
  logic [15:0] vq[$];

  always #4 clk = ~clk;

  pvic_top #(.N_AUX(NA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .req_i(req), .ext_lvl_i(ext), .ack_i(ack),
    .level_o(level), .evt_code_o(code)
  );

  function automatic logic [3:0] src_pri(int i);
    case (i)
      0: return m_pa[15:12];
      1: return m_pa[11:8];
      2, 3: return m_pa[7:4];
      4, 5, 6: return m_pa[3:0];
      7: return m_pb[15:12];
      8: return m_pb[11:8];
      9: return m_pb[7:4];
      default: return m_pb[3:0];
    endcase
  endfunction

  function automatic logic [11:0] src_code(int i);
    case (i)
      0: return 12'h400; 1: return 12'h420; 2: return 12'h440; 3: return 12'h460;
      4: return 12'h480; 5: return 12'h4A0; 6: return 12'h4C0; 7: return 12'h560;
      8: return 12'h620; 9: return 12'h600;
      default: return 12'hB00 + 12'(i - 10) * 12'h020;
    endcase
  endfunction

  // scan priorities from the top, lowest index first within a level
  task automatic model(input logic [NI-1:0] r, input logic [3:0] e,
                       output logic [3:0] lv, output logic [11:0] cd);
    lv = 0; cd = 0;
    for (int p = 15; p >= 1; p--) begin
      for (int i = 0; i < NI; i++) begin
        if (lv == 0 && r[i] && int'(src_pri(i)) == p && (i < 10 || !m_mask[i-10])) begin
          lv = 4'(p); cd = src_code(i);
        end
      end
      if (lv == 0 && e != 4'hF && 15 - int'(e) == p) begin
        lv = 4'(p); cd = 12'h200 + 12'(e) * 12'h020;
      end
    end
  endtask

  task automatic cyc(input logic [NI-1:0] r, input logic [3:0] e, input bit a, input string tag);
    logic [3:0] lv; logic [11:0] cd;
    @(negedge clk);
    wr_en = 0; req = r; ext = e; ack = a;
    model(r, e, lv, cd);
    if (a && lv != 0) exp_code = cd;
    #1;
    tq.push_back(tag); vq.push_back({lv, exp_code});
  endtask

  task automatic wr(input logic [1:0] ad, input logic [31:0] d, input string tag);
    logic [3:0] lv; logic [11:0] cd;
    @(negedge clk);
    wr_en = 1; wr_addr = ad; wr_data = d; ack = 0;
    model(req, ext, lv, cd);
    case (ad)
      2'd0: m_pa = d[15:0];
      2'd1: m_pb = d[15:0];
      2'd2: m_mask = m_mask | d;
      default: m_mask = m_mask & ~d;
    endcase
    #1;
    tq.push_back(tag); vq.push_back({lv, exp_code});
  endtask

  function automatic logic [NI-1:0] b(int i);
    logic [NI-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (tq.size() > 0) begin
        string t; logic [15:0] v;
        t = tq.pop_front(); v = vq.pop_front();
        nchk++;
        if (level !== v[15:12] || code !== v[11:0]) begin
          nerr++;
          $display("FAIL %s: level=%0d code=%03h expected level=%0d code=%03h",
                   t, level, code, v[15:12], v[11:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    nchk++;
    if (level !== 4'd0 || code !== 12'h000) begin
      nerr++;
      $display("FAIL R1 reset: level=%0d code=%03h expected level=0 code=000", level, code);
    end
    cyc(b(10), 4'hF, 1, "R1 aux masked after reset");
    wr(2'd1, 32'h9685, "R2 write B");
    cyc(b(10), 4'hF, 1, "R4 aux still masked");
    wr(2'd3, 32'h1, "R4 clear bit0");
    cyc(b(10), 4'hF, 1, "R4 aux0 unmasked");
    wr(2'd2, 32'h1, "R4 set bit0");
    cyc(b(10), 4'hF, 1, "R4 aux0 masked again");
    wr(2'd3, 32'h8000_0000, "R4 clear bit31");
    cyc(b(41), 4'hF, 1, "R3 aux31 shares field");
    wr(2'd0, 32'h1234, "R2 write A");
    cyc(b(0), 4'hF, 1, "R2 timer0");
    cyc(b(1), 4'hF, 0, "R2 timer1");
    cyc(b(2), 4'hF, 1, "R3 timer2 underflow");
    cyc(b(3), 4'hF, 1, "R3 timer2 capture");
    cyc(b(5), 4'hF, 1, "R3 rtc1");
    cyc(b(4) | b(6), 4'hF, 1, "R6 rtc tie");
    cyc(b(2) | b(3), 4'hF, 1, "R6 timer2 tie");
    cyc(b(0) | b(7) | b(8), 4'hF, 1, "R5 watchdog wins");
    cyc(b(8) | b(9), 4'hF, 1, "R5 debug wins");
    wr(2'd0, 32'h0234, "R2 write A zero field");
    cyc(b(0), 4'hF, 1, "R2 zero field disables");
    cyc('0, 4'h0, 1, "R7 ext level 0");
    cyc('0, 4'h5, 0, "R7 ext level 5");
    cyc('0, 4'hE, 1, "R7 ext level 14");
    cyc('0, 4'hF, 0, "R7 ext none");
    cyc(b(7), 4'h6, 1, "R6 internal beats ext tie");
    cyc(b(8), 4'hF, 0, "R8 hold without ack");
    cyc(b(8) | b(41), 4'hF, 0, "R9 two pending");
    cyc(b(41), 4'hF, 0, "R9 gpio withdrawn");
    cyc('0, 4'hF, 0, "R9 all withdrawn");
    cyc('0, 4'hF, 1, "R10 empty ack");
    cyc(b(8), 4'hF, 1, "R8 ack gpio");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule